// File: doc/BRIEF.md
# Master clock prescaler and post-divider

This block derives a master clock enable from one of four source clock strobes inside a single system clock domain. Each source is a one-cycle clock-enable strobe. The output is a train of one-cycle pulses, `mck_tick`. A control register picks the source and sets the division in two stages. The first stage is a prescaler that divides by a power of two, or by three when a build option enables it. The second stage is a post-divider whose ratio is read from a four-entry parameter table.

Software programs the control register through a small register port. It then polls a ready flag, or waits on a level interrupt, before it uses the clock. Every control write restarts both counters and drops the ready flag. The flag returns once the new chain has produced a full output period.

A parameter selects one of two register layouts. The layouts place the prescaler field at different bit positions and keep different sets of writable bits.

Top module: `mck_gen`

## Requirements
- R1: Control bits 1:0 select which of the four `src_tick` strobes feeds the division chain. Strobes on the other sources have no effect on `mck_tick`.
- R2: The 3-bit prescaler code n divides the selected strobe rate by 2^n. The code sits at control bits 4:2 when LAYOUT=0 and at bits 6:4 when LAYOUT=1.
- R3: Prescaler code 7 divides by 3 when DIV3_EN=1 and by 128 when DIV3_EN=0.
- R4: Control bits 9:8 index DIV_TABLE. After a control write, `mck_tick` pulses exactly on every (P*D)-th selected strobe, where P is the prescale ratio and D is the table entry.
- R5: A DIV_TABLE entry of 0 divides by 1.
- R6: Only writable control bits are stored: mask 0x31F for LAYOUT=0 and 0x373 for LAYOUT=1. Every other bit reads back as 0 at address 0.
- R7: A control write (address 0) clears the ready flag in the next cycle. The flag sets again in the cycle after the first `mck_tick` of the new setting.
- R8: A read of address 1 returns the ready flag in bit 0 and the interrupt enable in bit 1. All other bits read as 0.
- R9: Any write to address 2 sets the interrupt enable, and any write to address 3 clears it. `mck_irq` is high exactly while the ready flag and the enable are both set.
- R10: After reset the control register reads 0, ready is 0 and the enable is 0. Ready sets after the first output period of source 0 with prescaler 0 and table entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 4 | One-cycle enable strobes of the four sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 enable set, 3 enable clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mck_tick | output | 1 | Master clock enable pulse |
| mck_irq | output | 1 | Level interrupt: ready AND enable |

## Verification
The hardest situation to reach is the alignment of the first output pulse after a reconfiguration. Source strobes arrive at different rates, and the counters must restart from zero at the write. The bench drives the four sources at four different periods. It then sweeps every source, prescaler code and table index. For each setting it counts only the selected strobes from the write onward and compares every cycle against the predicted pulse positions. A second instance built with the other layout and without the divide-by-three option reaches the 128 ratio and the other field position.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int CTL_W   = 32;
  localparam int NSRC    = 4;
  localparam int SEL_W   = 2;
  localparam int PRE_W   = 3;
  localparam int DIVI_W  = 2;
  localparam int DIV_LSB = 8;
  localparam int PCNT_W  = 7;

  typedef enum logic [1:0] {
    A_CTL   = 2'd0,
    A_STAT  = 2'd1,
    A_IESET = 2'd2,
    A_IECLR = 2'd3
  } mck_addr_e;

  function automatic logic [CTL_W-1:0] ctl_mask(input int layout);
    return (layout == 0) ? 32'h0000_031F : 32'h0000_0373;
  endfunction

  function automatic int pre_lsb(input int layout);
    return (layout == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/mck_cnt.sv
module mck_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] limit,
  output logic         tick_out
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap     = (cnt_q == limit);
  assign tick_out = tick_in & wrap & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (tick_in) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt_q <= limit);
endmodule

// File: rtl/mck_regs.sv
module mck_regs
  import mck_pkg::*;
#(
  parameter int LAYOUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              mck_tick,
  output logic [CTL_W-1:0]  rdata,
  output logic [SEL_W-1:0]  sel,
  output logic [PRE_W-1:0]  pres,
  output logic [DIVI_W-1:0] didx,
  output logic              ctl_wr,
  output logic              ready,
  output logic              irq
);
  localparam logic [CTL_W-1:0] MASK = ctl_mask(LAYOUT);
  localparam int               PLSB = pre_lsb(LAYOUT);

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             rdy_q, rdy_d, ie_q, ie_d;
  mck_addr_e        a;

  assign a      = mck_addr_e'(addr);
  assign ctl_wr = wr && (a == A_CTL);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = wdata & MASK;
    rdy_d = rdy_q;
    if (ctl_wr)        rdy_d = 1'b0;
    else if (mck_tick) rdy_d = 1'b1;
    ie_d = ie_q;
    if (wr && a == A_IESET)      ie_d = 1'b1;
    else if (wr && a == A_IECLR) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rdy_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      rdy_q <= rdy_d;
      ie_q  <= ie_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (a)
      A_CTL:   rdata = ctl_q;
      A_STAT:  rdata = {{(CTL_W-2){1'b0}}, ie_q, rdy_q};
      default: rdata = '0;
    endcase
  end

  assign sel   = ctl_q[SEL_W-1:0];
  assign pres  = ctl_q[PLSB +: PRE_W];
  assign didx  = ctl_q[DIV_LSB +: DIVI_W];
  assign ready = rdy_q;
  assign irq   = rdy_q & ie_q;

  // R9
  ie_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie_q) |-> $past(wr && addr == 2'd2));
  // R6
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~MASK) == '0);
endmodule

// File: rtl/mck_gen.sv
module mck_gen
  import mck_pkg::*;
#(
  parameter int                     LAYOUT    = 1,
  parameter bit                     DIV3_EN   = 1'b1,
  parameter int                     DW        = 8,
  parameter logic [3:0][DW-1:0]     DIV_TABLE = {8'd8, 8'd4, 8'd2, 8'd1}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  src_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mck_tick,
  output logic        mck_irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [SEL_W-1:0]  sel;
  logic [PRE_W-1:0]  pres;
  logic [DIVI_W-1:0] didx;
  logic              ctl_wr, ready, sel_tick, pre_tick;
  logic [PCNT_W-1:0] pre_lim;
  logic [DW-1:0]     entry, post_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  mck_regs #(.LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .mck_tick(mck_tick), .rdata(reg_rdata),
    .sel(sel), .pres(pres), .didx(didx), .ctl_wr(ctl_wr),
    .ready(ready), .irq(mck_irq)
  );

  assign sel_tick = src_tick[sel];

  always_comb begin
    if (DIV3_EN && pres == 3'd7) pre_lim = PCNT_W'(2);
    else                         pre_lim = PCNT_W'((8'd1 << pres) - 8'd1);
    entry    = DIV_TABLE[didx];
    post_lim = (entry == '0) ? '0 : entry - 1'b1;
  end

  mck_cnt #(.W(PCNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n_i), .clr(ctl_wr), .tick_in(sel_tick),
    .limit(pre_lim), .tick_out(pre_tick)
  );

  mck_cnt #(.W(DW)) u_post (
    .clk(clk), .rst_n(rst_n_i), .clr(ctl_wr), .tick_in(pre_tick),
    .limit(post_lim), .tick_out(mck_tick)
  );

  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ctl_wr |=> !ready);
  // R7
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(ready) |-> $past(mck_tick));
  // R1
  tick_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    mck_tick |-> src_tick[sel]);
endmodule

// File: tb/tb_mck_gen.sv
module tb_mck_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        tick_a, tick_b, irq_a, irq_b;
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  mck_gen #(.LAYOUT(1), .DIV3_EN(1'b1), .DW(8),
            .DIV_TABLE({8'd0, 8'd2, 8'd3, 8'd5})) dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(wr_a),
    .reg_addr(bus_addr), .reg_wdata(bus_wdata), .reg_rdata(rdata_a),
    .mck_tick(tick_a), .mck_irq(irq_a));

  mck_gen #(.LAYOUT(0), .DIV3_EN(1'b0), .DW(8)) dut_alt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(wr_b),
    .reg_addr(bus_addr), .reg_wdata(bus_wdata), .reg_rdata(rdata_b),
    .mck_tick(tick_b), .mck_irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tbl(input bit b, input int i);
    int a[4] = '{5, 3, 2, 0};
    int c[4] = '{1, 2, 4, 8};
    return b ? c[i] : a[i];
  endfunction

  function automatic int ratio(input bit b, input int pres, input int didx);
    int p, d;
    if (!b && pres == 7) p = 3;
    else                 p = 1 << pres;
    d = tbl(b, didx);
    if (d == 0) d = 1;
    return p * d;
  endfunction

  task automatic wr_reg(input bit b, input logic [1:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; src_tick = '0;
    wr_a = !b; wr_b = b;
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  function automatic logic [31:0] rd(input bit b);
    return b ? rdata_b : rdata_a;
  endfunction

  task automatic run_cfg(input bit b, input int sel, input int pres, input int didx, input string req);
    int pd, k, errs, nsel;
    logic exp_t, act_t;
    pd = ratio(b, pres, didx);
    wr_reg(b, 2'd0, sel | (pres << (b ? 2 : 4)) | (didx << 8));
    bus_addr = 2'd1;
    #1 chk({req, "/R7 ready low after write"}, rd(b) & 32'h1, 32'h0);
    k = 0; errs = 0; nsel = 0;
    while (nsel < 2 * pd) begin
      cyc++;
      for (int i = 0; i < 4; i++) src_tick[i] = (cyc % (i + 1) == 0);
      #1;
      exp_t = src_tick[sel] && ((k + 1) % pd == 0);
      act_t = b ? tick_b : tick_a;
      if (act_t !== exp_t) errs++;
      if (src_tick[sel]) begin k++; nsel++; end
      @(negedge clk);
    end
    src_tick = '0;
    chk({req, " pulse positions"}, errs, 0);
    #1 chk({req, "/R7 ready after period"}, rd(b) & 32'h1, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_addr = 2'd0;
    #1 chk("R10 ctl reset", rdata_a, 32'h0);
    bus_addr = 2'd1;
    #1 chk("R10 status reset", rdata_a, 32'h0);
    chk("R10 irq reset", {31'b0, irq_a}, 32'h0);
    // R10: source 0, ratio 1*5, strobes every cycle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); src_tick = 4'hF;
    end
    @(negedge clk); src_tick = '0;
    #1 chk("R10 ready after first period", rdata_a & 32'h1, 32'h1);

    // R6 masks
    wr_reg(0, 2'd0, 32'hFFFF_FFFF);
    bus_addr = 2'd0;
    #1 chk("R6 mask layout1", rdata_a, 32'h0000_0373);
    wr_reg(1, 2'd0, 32'hFFFF_FFFF);
    bus_addr = 2'd0;
    #1 chk("R6 mask layout0", rdata_b, 32'h0000_031F);
    bus_addr = 2'd2;
    #1 chk("R6 unmapped read", rdata_a, 32'h0);

    // R1 R2 R3 R4 R5 full sweep on layout 1 with divide-by-three
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++)
        for (int d = 0; d < 4; d++)
          run_cfg(0, s, p, d, "R1/R2/R3/R4/R5 sweep");

    // R2 R3 layout 0, code 7 = 128
    for (int p = 0; p < 8; p++) run_cfg(1, 1, p, 1, "R2/R3 layout0");

    // R8 R9 interrupt
    wr_reg(0, 2'd2, 32'h0);
    bus_addr = 2'd1;
    #1 chk("R8 status ready+ie", rdata_a, 32'h3);
    chk("R9 irq high", {31'b0, irq_a}, 32'h1);
    wr_reg(0, 2'd3, 32'h0);
    bus_addr = 2'd1;
    #1 chk("R8 status ie cleared", rdata_a, 32'h1);
    chk("R9 irq low after clear", {31'b0, irq_a}, 32'h0);
    wr_reg(0, 2'd2, 32'h0);
    run_cfg(0, 0, 1, 1, "R9 rearm");
    chk("R9 irq after reconfig", {31'b0, irq_a}, 32'h1);
    wr_reg(0, 2'd0, 32'h0);
    #1 chk("R9 irq drops on control write", {31'b0, irq_a}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule